// File: doc/BRIEF.md
# Edge-Counting Tag Reply Receiver

This block recovers a short reply that a passive tag sends back to a reader. The reply arrives as a demodulated digital line. A logic one shows as a burst of level changes, and a logic zero shows as a quiet line. The reader pulses `start_i` at the moment its own transmission ends. It gives the number of reply bits it expects and a keystream word. The block then waits a fixed turnaround time and opens one bit window per expected bit, each exactly one tag bit period long. In each window it counts the transitions of the synchronised line.

A window whose count lies strictly between a lower and an upper threshold is taken as a one. A detected one flips the matching bit of the keystream word, so the result comes out already de-obfuscated, with the first received bit at bit 0. When the last window closes, the word appears on `data_o` and `valid_o` pulses for one cycle. A request for more bits than the word holds is refused with a one-cycle `abort_o`, and nothing is received.

Timing is counted in ticks. A tick is `CLK_PER_TICK` clock cycles; by default one tick is two thirds of a microsecond. The default turnaround is 490 ticks and the default bit period is 150 ticks (100 us). Window boundaries are derived from a counter that restarts exactly at each boundary, so the windows never drift against the tag.

The controller has five states:
- `ST_IDLE`: waits for `start_i`. Go to `ST_REFUSE` if the requested count is too large, otherwise to `ST_TURN`.
- `ST_REFUSE`: drives the abort pulse, then returns to `ST_IDLE`.
- `ST_TURN`: times the turnaround. At its end, go to `ST_FINISH` if zero bits were asked for, otherwise to `ST_WIN`.
- `ST_WIN`: one bit window. It stays in `ST_WIN` for each further bit and goes to `ST_FINISH` when the last window closes.
- `ST_FINISH`: drives the valid pulse, then returns to `ST_IDLE`.

Top module: `tag_edge_receiver`

## Requirements
- R1: After reset, `valid_o` and `abort_o` are 0 and `data_o` is 0.
- R2: A start with `nbits_i` greater than `MAX_BITS` (32) raises `abort_o` for exactly the one cycle after the start edge. `valid_o` stays low and `data_o` keeps its previous value.
- R3: For an accepted start with n bits, `valid_o` is high in exactly the cycle that follows clock edge number `CLK_PER_TICK*(TURN_TICKS + n*BIT_TICKS)` counted from the start edge. It is low before that cycle and low again in the next cycle.
- R4: A window decodes as one exactly when its edge count c satisfies `LOW_THR < c < HIGH_THR` (30 < c < 64). Counts of 30, 64 or more, and 0 decode as zero.
- R5: The line passes through a two-flop synchroniser, and both rising and falling transitions count as edges. An odd count such as 31 decodes as a one.
- R6: Received bit i (first window is i = 0) flips bit i of `key_i` when it is one. Bits at positions n and above equal `key_i`.
- R7: The per-window edge counter saturates at `HIGH_THR` and never wraps, so 70 edges decode as zero.
- R8: `start_i` is ignored while a reception is in progress. No abort is raised, and the running frame's timing and result are unchanged.
- R9: A start with `nbits_i` = 0 gives `valid_o` after the turnaround alone, with `data_o` equal to `key_i`.
- R10: `data_o` changes only together with a `valid_o` pulse and holds its value otherwise.
- R11: Transitions during the turnaround are not counted in any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle, at end of reader transmission |
| nbits_i | input | 7 | Number of reply bits expected |
| key_i | input | 32 | Keystream word preloaded into the result |
| rx_i | input | 1 | Demodulated tag line, asynchronous |
| data_o | output | 32 | De-obfuscated reply, LSB received first |
| valid_o | output | 1 | One-cycle pulse when the last window closes |
| abort_o | output | 1 | One-cycle pulse when a request is refused |

## Verification
The bench builds the block with `CLK_PER_TICK` = 2, `TURN_TICKS` = 25 and `BIT_TICKS` = 80. It keeps the default thresholds (30 and 64) and the default `MAX_BITS` of 32. A window is then 160 cycles long, which leaves room to place up to about 70 toggles, two cycles apart, well inside each window. This brings the upper threshold and the saturation point within reach, and a full 32-bit frame fits in a few thousand cycles. With a tick of two cycles, the prescaler's part in the exact valid latency is also checked, which a one-cycle tick would hide.

// File: rtl/tag_rx_pkg.sv
package tag_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REFUSE,
        ST_TURN,
        ST_WIN,
        ST_FINISH
    } rx_state_e;

    // Window decision: strictly between the two thresholds
    function automatic logic window_is_one(input int unsigned cnt,
                                           input int unsigned lo,
                                           input int unsigned hi);
        return (cnt > lo) && (cnt < hi);
    endfunction

endpackage

// File: rtl/rx_input_sync.sv
module rx_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic edge_o
);
    // stage[0..STAGES-1] synchronise, stage[STAGES] holds previous level
    logic [STAGES:0] stage_q;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= rx_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    // Either polarity of transition counts
    assign edge_o = stage_q[STAGES-1] ^ stage_q[STAGES];

endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_q;

    assign tick_o = run_i && (pre_q == PW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pre_q <= '0;
        else if (!run_i || tick_o) pre_q <= '0;
        else                       pre_q <= pre_q + PW'(1);
    end

endmodule

// File: rtl/rx_edge_counter.sv
module rx_edge_counter #(
    parameter int MAX_CNT = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         edge_i,
    output logic [$clog2(MAX_CNT+1)-1:0] count_now_o
);
    localparam int CW = $clog2(MAX_CNT + 1);

    logic [CW-1:0] count_q;

    // Count including an edge in the current cycle, saturating
    always_comb begin
        if (count_q == CW'(MAX_CNT)) count_now_o = count_q;
        else                         count_now_o = count_q + CW'(edge_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (clear_i) count_q <= '0;
        else              count_q <= count_now_o;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(MAX_CNT)); // R7

endmodule

// File: rtl/tag_edge_receiver.sv
module tag_edge_receiver
    import tag_rx_pkg::*;
#(
    parameter int CLK_PER_TICK = 1,
    parameter int TURN_TICKS   = 490,
    parameter int BIT_TICKS    = 150,
    parameter int MAX_BITS     = 32,
    parameter int LOW_THR      = 30,
    parameter int HIGH_THR     = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [$clog2(MAX_BITS+1):0]       nbits_i,
    input  logic [MAX_BITS-1:0]               key_i,
    input  logic                              rx_i,
    output logic [MAX_BITS-1:0]               data_o,
    output logic                              valid_o,
    output logic                              abort_o
);
    localparam int NB_W    = $clog2(MAX_BITS + 1) + 1;
    localparam int IDX_W   = $clog2(MAX_BITS);
    localparam int TMAX    = (TURN_TICKS > BIT_TICKS) ? TURN_TICKS : BIT_TICKS;
    localparam int TIMER_W = $clog2(TMAX + 1);
    localparam int CNT_W   = $clog2(HIGH_THR + 1);

    rx_state_e           state_q, state_d;
    logic [TIMER_W-1:0]  timer_q;
    logic [IDX_W-1:0]    idx_q;
    logic [NB_W-1:0]     nbits_q;
    logic [MAX_BITS-1:0] work_q, work_flip;
    logic [MAX_BITS-1:0] result_q;

    logic             tick, edge_pulse, bit_one;
    logic             close_turn, close_win, last_win, accept;
    logic [CNT_W-1:0] count_now;

    // ---------------- sub-blocks ----------------
    rx_input_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .edge_o (edge_pulse)
    );

    rx_tick_gen #(.DIV(CLK_PER_TICK)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  ((state_q == ST_TURN) || (state_q == ST_WIN)),
        .tick_o (tick)
    );

    rx_edge_counter #(.MAX_CNT(HIGH_THR)) i_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     ((state_q != ST_WIN) || close_win),
        .edge_i      (edge_pulse),
        .count_now_o (count_now)
    );

    // ---------------- decode helpers ----------------
    assign accept     = (nbits_i <= NB_W'(MAX_BITS));
    assign close_turn = (state_q == ST_TURN) && tick && (timer_q == TIMER_W'(TURN_TICKS - 1));
    assign close_win  = (state_q == ST_WIN)  && tick && (timer_q == TIMER_W'(BIT_TICKS - 1));
    assign last_win   = close_win && ((NB_W'(idx_q) + NB_W'(1)) == nbits_q);
    assign bit_one    = window_is_one(32'(count_now), LOW_THR, HIGH_THR);
    assign work_flip  = work_q ^ (MAX_BITS'(bit_one) << idx_q);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = accept ? ST_TURN : ST_REFUSE;
            ST_REFUSE: state_d = ST_IDLE;
            ST_TURN:   if (close_turn) state_d = (nbits_q == '0) ? ST_FINISH : ST_WIN;
            ST_WIN:    if (last_win) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q  <= '0;
            idx_q    <= '0;
            nbits_q  <= '0;
            work_q   <= '0;
            result_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i && accept) begin
                nbits_q <= nbits_i;
                work_q  <= key_i;
                idx_q   <= '0;
                timer_q <= '0;
            end
            if ((state_q == ST_TURN || state_q == ST_WIN) && tick) begin
                if (close_turn || close_win) timer_q <= '0;
                else                         timer_q <= timer_q + TIMER_W'(1);
            end
            if (close_win) begin
                work_q <= work_flip;
                idx_q  <= idx_q + IDX_W'(1);
            end
            if (close_turn && nbits_q == '0) result_q <= work_q;
            if (last_win)                    result_q <= work_flip;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        valid_o = (state_q == ST_FINISH);
        abort_o = (state_q == ST_REFUSE);
        data_o  = result_q;
    end

    // ---------------- assertions ----------------
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R3

    AST_REFUSE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && nbits_i > NB_W'(MAX_BITS)) |=> (abort_o && !valid_o)); // R2

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> valid_o); // R10

    AST_BUSY_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TURN || state_q == ST_WIN) && start_i) |=> !abort_o); // R8

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WIN) |-> (NB_W'(idx_q) < nbits_q)); // R6

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && abort_o)); // R2

endmodule

// File: tb/test_tag_edge_receiver.sv
module test_tag_edge_receiver;

    localparam int DIV  = 2;
    localparam int TURN = 25;
    localparam int BITT = 80;
    localparam int MAXB = 32;
    localparam int W    = DIV * BITT;
    localparam int T0   = DIV * TURN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  nbits_i = '0;
    logic [31:0] key_i = '0;
    logic        rx_i = 1'b0;
    logic [31:0] data_o;
    logic        valid_o, abort_o;

    int n_checks = 0;
    int n_fail   = 0;
    int ecount [32];

    always #5 clk = ~clk;

    tag_edge_receiver #(
        .CLK_PER_TICK(DIV), .TURN_TICKS(TURN), .BIT_TICKS(BITT),
        .MAX_BITS(MAXB), .LOW_THR(30), .HIGH_THR(64), .SYNC_STAGES(2)
    ) i_tag_edge_receiver (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbits_i(nbits_i),
        .key_i(key_i), .rx_i(rx_i), .data_o(data_o), .valid_o(valid_o),
        .abort_o(abort_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input int n, input logic [31:0] key);
        logic [31:0] r = key;
        for (int i = 0; i < n; i++)
            if (ecount[i] > 30 && ecount[i] < 64) r[i] = ~r[i];
        return r;
    endfunction

    task automatic run_frame(input int n, input logic [31:0] key,
                             input bit poke_busy, input string req);
        logic [31:0] exp;
        int lat, t;
        bit early, abort_seen;
        exp = expect_word(n, key);
        lat = T0 + n * W;
        early = 0; abort_seen = 0;
        @(negedge clk);
        start_i = 1'b1; nbits_i = 7'(n); key_i = key;
        @(posedge clk);
        t = 0;
        while (t <= lat + 1) begin
            @(negedge clk);
            if (t == 0) start_i = 1'b0;
            // R11: noise during the turnaround
            if (t >= 2 && t <= T0 - 10 && (t % 2) == 0) rx_i = ~rx_i;
            if (t >= T0) begin
                int rel, w, off;
                rel = t - T0; w = rel / W; off = rel % W;
                if (w < n && off >= 10 && ((off - 10) % 2) == 0 && ((off - 10) / 2) < ecount[w])
                    rx_i = ~rx_i;
            end
            if (poke_busy && t == T0 + 5) begin
                start_i = 1'b1; nbits_i = 7'd40; key_i = ~key;
            end
            if (poke_busy && t == T0 + 6) start_i = 1'b0;
            if (abort_o) abort_seen = 1;
            if (t < lat && valid_o) early = 1;
            if (t == lat) begin
                chk(valid_o == 1'b1, {req, " R3 valid at latency"}, 32'(valid_o), 32'd1);
                chk(data_o == exp, {req, " R6 data"}, data_o, exp);
            end
            if (t == lat + 1)
                chk(valid_o == 1'b0, {req, " R3 valid one cycle"}, 32'(valid_o), 32'd0);
            @(posedge clk);
            t++;
        end
        chk(!early, {req, " R3 no early valid"}, 32'(early), 32'd0);
        chk(!abort_seen, {req, " R8 no abort"}, 32'(abort_seen), 32'd0);
    endtask

    task automatic run_refuse(input int n);
        logic [31:0] prev;
        bit v_seen;
        prev = data_o; v_seen = 0;
        @(negedge clk);
        start_i = 1'b1; nbits_i = 7'(n); key_i = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(abort_o == 1'b1, "R2 abort raised", 32'(abort_o), 32'd1);
        chk(valid_o == 1'b0, "R2 no valid", 32'(valid_o), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(abort_o == 1'b0, "R2 abort one cycle", 32'(abort_o), 32'd0);
        for (int k = 0; k < T0 + W; k++) begin
            @(negedge clk);
            if (valid_o) v_seen = 1;
        end
        chk(!v_seen, "R2 nothing received", 32'(v_seen), 32'd0);
        chk(data_o == prev, "R10 data held after refusal", data_o, prev);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b0, "R1 reset valid", 32'(valid_o), 32'd0);
        chk(abort_o == 1'b0, "R1 reset abort", 32'(abort_o), 32'd0);
        chk(data_o == 32'd0, "R1 reset data", data_o, 32'd0);

        // R4 / R7: threshold edges and saturation
        ecount[0] = 30; ecount[1] = 31; ecount[2] = 42; ecount[3] = 63;
        ecount[4] = 64; ecount[5] = 70; ecount[6] = 0;
        run_frame(7, 32'h0, 0, "R4 R7 thresholds");

        // R5: odd count needs both polarities
        ecount[0] = 31;
        run_frame(1, 32'h0, 0, "R5 both edges");

        // R6: keystream XOR, LSB first, upper bits from key
        for (int i = 0; i < 8; i++) ecount[i] = 0;
        ecount[0] = 42; ecount[3] = 42; ecount[7] = 42;
        run_frame(8, 32'hA5A5_5A5A, 0, "R6 key xor");

        // R11: turnaround noise, quiet window
        ecount[0] = 0;
        run_frame(1, 32'h0000_0001, 0, "R11 turnaround ignored");

        // R9: zero bits
        run_frame(0, 32'h1357_9BDF, 0, "R9 zero bits");

        // R2 / R10: refusals
        run_refuse(33);
        run_refuse(127);

        // R8: start while busy
        ecount[0] = 42; ecount[1] = 10; ecount[2] = 50;
        run_frame(3, 32'hF0F0_0F0F, 1, "R8 busy start");

        // R6: full width
        for (int i = 0; i < 32; i++) ecount[i] = (i % 3 == 0) ? 45 : ((i % 3 == 1) ? 5 : 66);
        run_frame(32, 32'h0123_4567, 0, "R6 full width");

        // R10: data held while idle
        begin
            logic [31:0] keep;
            keep = data_o;
            repeat (20) @(negedge clk);
            chk(data_o == keep, "R10 data held idle", data_o, keep);
        end

        // Random frames
        for (int f = 0; f < 20; f++) begin
            int n;
            n = int'($urandom_range(6, 1));
            for (int i = 0; i < n; i++) ecount[i] = int'($urandom_range(72, 0));
            run_frame(n, $urandom, 0, "R4 R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule